// File: doc/BRIEF.md
# Coefficient-Loading Two-Wire Write Slave

This block is a write-only slave on a two-wire serial control bus (I2C). A host uses it to load 16-bit filter coefficients into an on-chip coefficient memory. The block oversamples the bus clock and data lines with the system clock. It recognises start and stop conditions and compares the first byte with its device address, two bits of which come from board straps. After that it produces a single-cycle write strobe for each coefficient it receives.

The byte that follows the address gives the memory location of the first coefficient. Each coefficient arrives as two bytes, high byte first, and later coefficients go to consecutive locations. One transfer carries a limited number of coefficients. One memory location is reserved for the mode register. A transfer that starts there carries exactly one word. Any byte that exceeds the allowance is refused with a not-acknowledge and is never written.

Top module: `coef_i2c_slave`

## Requirements
- R1: A start condition (data falling while clock is high) restarts address reception at any point, including in the middle of a transfer. A stop condition (data rising while clock is high) ends the transfer and releases the data line.
- R2: A first byte equal to binary 0011 0, then strap bit 1, then strap bit 0, then a 0 in the direction bit, is acknowledged. The data line is held low from the falling clock edge after the eighth bit, and through the high phase of the ninth clock.
- R3: A first byte that does not match, or that has the direction bit set to 1, receives no acknowledge. No later byte of that transfer is acknowledged or written.
- R4: The second byte is acknowledged and becomes the memory address of the first coefficient.
- R5: Data bytes pair into words, high byte first. A single-cycle write strobe follows each low byte, with data {high, low} at the current address. The address then increments by one and wraps at the top of the address range.
- R6: A transfer writes at most four words. Any later data byte is not acknowledged and causes no write.
- R7: When the second byte equals the mode-register address FF hex, the transfer writes exactly one word. Bytes after that word are not acknowledged.
- R8: A high byte that is not followed by its low byte before a stop or start causes no write.
- R9: The acknowledge is released on the falling clock edge that ends the ninth clock.
- R10: After reset the data line is released and the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Board-strapped device address bits (bit 1 above bit 0) |
| sda_pull_o | output | 1 | High pulls the data line low (acknowledge) |
| wr_en_o | output | 1 | Single-cycle coefficient write strobe |
| wr_addr_o | output | 8 | Coefficient memory address for the write |
| wr_data_o | output | 16 | Coefficient word for the write |

## Verification
The bench sends a burst of five words. An off-by-one in the word limit would either accept the fifth word or drop the fourth. A burst aimed at the mode register checks the one-word cut: a design that ignored it would write the next location as well. The bench also sends mismatched and read-direction addresses, changes the straps, and cuts a word in half with a stop. A block that decoded the wrong address bits, or that wrote a half-formed word, would show a stray acknowledge or a stray strobe. A repeated start in the middle of a transfer must drop the pending byte and start a new burst. The acknowledge window is sampled on both sides of the falling edge after the ninth clock, which exposes an acknowledge that is released late.

// File: rtl/coef_i2c_pkg.sv
package coef_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_REG,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/coef_i2c_sync.sv
module coef_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_lvl_o,
  output logic start_o,
  output logic stop_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] scl_sh_q, sda_sh_q;
  logic         scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= {scl_sh_q[W-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[W-2:0], sda_i};
    end
  end

  always_comb begin
    scl_now    = scl_sh_q[STAGES-1];
    scl_old    = scl_sh_q[STAGES];
    sda_now    = sda_sh_q[STAGES-1];
    sda_old    = sda_sh_q[STAGES];
    scl_rise_o = scl_now & ~scl_old;
    scl_fall_o = ~scl_now & scl_old;
    sda_lvl_o  = sda_now;
    start_o    = scl_now & scl_old & sda_old & ~sda_now;
    stop_o     = scl_now & scl_old & ~sda_old & sda_now;
  end
endmodule

// File: rtl/coef_i2c_bitcnt.sv
module coef_i2c_bitcnt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_rst_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  output logic [7:0] byte_o,
  output logic [3:0] cnt_o,
  output logic       byte_done_o,
  output logic       slot_end_o
);
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] byte_q, byte_d;

  always_comb begin
    cnt_d  = cnt_q;
    byte_d = byte_q;
    if (frame_rst_i) begin
      cnt_d = 4'd0;
    end else if (scl_rise_i && cnt_q < 4'd9) begin
      cnt_d = cnt_q + 4'd1;
      if (cnt_q < 4'd8) byte_d = {byte_q[6:0], sda_lvl_i};
    end else if (scl_fall_i && cnt_q == 4'd9) begin
      cnt_d = 4'd0;
    end
    byte_done_o = scl_fall_i && (cnt_q == 4'd8) && !frame_rst_i;
    slot_end_o  = scl_fall_i && (cnt_q == 4'd9) && !frame_rst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 4'd0;
      byte_q <= 8'd0;
    end else begin
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
    end
  end

  assign byte_o = byte_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/coef_i2c_ctrl.sv
module coef_i2c_ctrl
  import coef_i2c_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          MAX_WORDS  = 4,
  parameter logic [7:0]  MODE_ADDR  = 8'hFF,
  parameter logic [4:0]  DEV_PREFIX = 5'b00110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic              slot_end_i,
  input  logic [7:0]        byte_i,
  input  logic [3:0]        bit_cnt_i,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o
);
  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam logic [CW-1:0] LIM_FULL = CW'(MAX_WORDS);
  localparam logic [CW-1:0] LIM_ONE  = CW'(1);

  phase_t            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d, wa_q, wa_d;
  logic [7:0]        hi_q, hi_d;
  logic              hi_sel_q, hi_sel_d;
  logic              mode_q, mode_d;
  logic [CW-1:0]     wcnt_q, wcnt_d, limit;
  logic              ack_q, ack_d;
  logic              we_q, we_d;
  logic [15:0]       wd_q, wd_d;
  logic              addr_hit;

  always_comb begin
    limit    = mode_q ? LIM_ONE : LIM_FULL;
    addr_hit = (byte_i == {DEV_PREFIX, strap_i, 1'b0});
    phase_d  = phase_q;
    addr_d   = addr_q;
    wa_d     = wa_q;
    hi_d     = hi_q;
    hi_sel_d = hi_sel_q;
    mode_d   = mode_q;
    wcnt_d   = wcnt_q;
    ack_d    = ack_q;
    we_d     = 1'b0;
    wd_d     = wd_q;
    if (slot_end_i) ack_d = 1'b0;
    case (phase_q)
      PH_ADDR: if (byte_done_i) begin
        if (addr_hit) begin
          ack_d   = 1'b1;
          phase_d = PH_REG;
        end else begin
          phase_d = PH_SKIP;
        end
      end
      PH_REG: if (byte_done_i) begin
        ack_d    = 1'b1;
        addr_d   = ADDR_W'(byte_i);
        mode_d   = (byte_i == MODE_ADDR);
        wcnt_d   = '0;
        hi_sel_d = 1'b1;
        phase_d  = PH_DATA;
      end
      PH_DATA: if (byte_done_i && wcnt_q < limit) begin
        ack_d = 1'b1;
        if (hi_sel_q) begin
          hi_d     = byte_i;
          hi_sel_d = 1'b0;
        end else begin
          we_d     = 1'b1;
          wd_d     = {hi_q, byte_i};
          wa_d     = addr_q;
          addr_d   = addr_q + ADDR_W'(1);
          wcnt_d   = wcnt_q + CW'(1);
          hi_sel_d = 1'b1;
        end
      end
      default: ;
    endcase
    if (start_i) begin
      phase_d  = PH_ADDR;
      ack_d    = 1'b0;
      hi_sel_d = 1'b1;
    end else if (stop_i) begin
      phase_d  = PH_IDLE;
      ack_d    = 1'b0;
      hi_sel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      addr_q   <= '0;
      wa_q     <= '0;
      hi_q     <= '0;
      hi_sel_q <= 1'b1;
      mode_q   <= 1'b0;
      wcnt_q   <= '0;
      ack_q    <= 1'b0;
      we_q     <= 1'b0;
      wd_q     <= '0;
    end else begin
      phase_q  <= phase_d;
      addr_q   <= addr_d;
      wa_q     <= wa_d;
      hi_q     <= hi_d;
      hi_sel_q <= hi_sel_d;
      mode_q   <= mode_d;
      wcnt_q   <= wcnt_d;
      ack_q    <= ack_d;
      we_q     <= we_d;
      wd_q     <= wd_d;
    end
  end

  assign ack_o     = ack_q;
  assign wr_en_o   = we_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;

  assert_ack_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (bit_cnt_i == 4'd8 || bit_cnt_i == 4'd9));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (!ack_q && phase_q == PH_IDLE));

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> (!ack_q && !we_q));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  assert_word_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (wcnt_q != '0 && wcnt_q <= LIM_FULL));

  assert_mode_one_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && mode_q) |-> (wcnt_q == LIM_ONE));
endmodule

// File: rtl/coef_i2c_slave.sv
module coef_i2c_slave #(
  parameter int         ADDR_W      = 8,
  parameter int         MAX_WORDS   = 4,
  parameter logic [7:0] MODE_ADDR   = 8'hFF,
  parameter logic [4:0] DEV_PREFIX  = 5'b00110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o
);
  logic       scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic [7:0] rx_byte;
  logic [3:0] bit_cnt;
  logic       byte_done, slot_end;

  coef_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .sda_lvl_o  (sda_lvl),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  coef_i2c_bitcnt u_bitcnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_rst_i (start_det | stop_det),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_lvl_i   (sda_lvl),
    .byte_o      (rx_byte),
    .cnt_o       (bit_cnt),
    .byte_done_o (byte_done),
    .slot_end_o  (slot_end)
  );

  coef_i2c_ctrl #(
    .ADDR_W     (ADDR_W),
    .MAX_WORDS  (MAX_WORDS),
    .MODE_ADDR  (MODE_ADDR),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap_i),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .byte_done_i (byte_done),
    .slot_end_i  (slot_end),
    .byte_i      (rx_byte),
    .bit_cnt_i   (bit_cnt),
    .ack_o       (sda_pull_o),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o)
  );
endmodule

// File: tb/test_coef_i2c_slave.sv
module test_coef_i2c_slave;
  localparam int Q = 6;

  logic        clk, rst_n, scl, m_sda;
  logic [1:0]  strap;
  logic        sda_pull, wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        bus_sda;

  int n_chk = 0, n_fail = 0, n_wr = 0;
  logic [7:0]  log_a [16];
  logic [15:0] log_d [16];
  logic        rel_ok;

  assign bus_sda = m_sda & ~sda_pull;

  coef_i2c_slave i_coef_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .strap_i(strap),
    .sda_pull_o(sda_pull), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && wr_en) begin
    if (n_wr < 16) begin
      log_a[n_wr] = wr_addr;
      log_d[n_wr] = wr_data;
    end
    n_wr = n_wr + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    scl = 1'b0; m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; m_sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(Q);
      m_sda = b[i]; tick(Q);
      scl = 1'b1; tick(2 * Q);
    end
    scl = 1'b0; tick(Q);
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack = sda_pull;
    tick(Q);
    scl = 1'b0; tick(Q);
    rel_ok = !sda_pull;
  endtask

  task automatic t_reset();
    check("R10 pull after reset", {31'd0, sda_pull}, 32'd0);
    check("R10 strobe after reset", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_bad_addr();
    logic a;
    n_wr = 0; strap = 2'b00;
    bus_start();
    send_byte(8'h36, a);
    check("R3 mismatched address nack", {31'd0, a}, 32'd0);
    send_byte(8'h10, a);
    check("R3 later byte nack", {31'd0, a}, 32'd0);
    send_byte(8'h12, a); send_byte(8'h34, a);
    bus_stop();
    check("R3 no writes", n_wr, 0);
    n_wr = 0;
    bus_start();
    send_byte(8'h31, a);
    check("R3 read direction nack", {31'd0, a}, 32'd0);
    bus_stop();
    check("R3 read direction no writes", n_wr, 0);
  endtask

  task automatic t_burst();
    logic a;
    logic [15:0] w [5] = '{16'h1234, 16'hABCD, 16'h0F0F, 16'h8001, 16'h5555};
    n_wr = 0; strap = 2'b10;
    bus_start();
    send_byte(8'h34, a);
    check("R2 strap 10 address ack", {31'd0, a}, 32'd1);
    check("R9 ack released after ninth clock", {31'd0, rel_ok}, 32'd1);
    send_byte(8'h10, a);
    check("R4 register byte ack", {31'd0, a}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      send_byte(w[k][15:8], a);
      check("R5 high byte ack", {31'd0, a}, 32'd1);
      send_byte(w[k][7:0], a);
      check("R5 low byte ack", {31'd0, a}, 32'd1);
    end
    send_byte(w[4][15:8], a);
    check("R6 fifth word high nack", {31'd0, a}, 32'd0);
    send_byte(w[4][7:0], a);
    check("R6 fifth word low nack", {31'd0, a}, 32'd0);
    bus_stop();
    check("R6 four writes", n_wr, 4);
    for (int k = 0; k < 4; k++) begin
      check("R5 write address", {24'd0, log_a[k]}, 32'h10 + k);
      check("R5 write data", {16'd0, log_d[k]}, {16'd0, w[k]});
    end
    check("R1 pull released after stop", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic t_mode();
    logic a;
    n_wr = 0; strap = 2'b01;
    bus_start();
    send_byte(8'h32, a);
    check("R2 strap 01 address ack", {31'd0, a}, 32'd1);
    send_byte(8'hFF, a);
    send_byte(8'hA5, a); send_byte(8'h5A, a);
    check("R7 first word ack", {31'd0, a}, 32'd1);
    send_byte(8'h11, a);
    check("R7 second word nack", {31'd0, a}, 32'd0);
    send_byte(8'h22, a);
    bus_stop();
    check("R7 one write", n_wr, 1);
    check("R7 write address", {24'd0, log_a[0]}, 32'hFF);
    check("R7 write data", {16'd0, log_d[0]}, 32'hA55A);
  endtask

  task automatic t_wrap_partial();
    logic a;
    n_wr = 0; strap = 2'b11;
    bus_start();
    send_byte(8'h36, a);
    check("R2 strap 11 address ack", {31'd0, a}, 32'd1);
    send_byte(8'hFE, a);
    send_byte(8'h01, a); send_byte(8'h02, a);
    send_byte(8'h03, a); send_byte(8'h04, a);
    send_byte(8'h05, a); send_byte(8'h06, a);
    send_byte(8'h77, a);
    bus_stop();
    check("R8 partial word dropped", n_wr, 3);
    check("R5 wrap address", {24'd0, log_a[2]}, 32'h00);
    check("R5 wrap data", {16'd0, log_d[2]}, 32'h0506);
  endtask

  task automatic t_restart();
    logic a;
    n_wr = 0; strap = 2'b00;
    bus_start();
    send_byte(8'h30, a);
    send_byte(8'h40, a);
    send_byte(8'h99, a);
    bus_start();
    send_byte(8'h30, a);
    check("R1 repeated start address ack", {31'd0, a}, 32'd1);
    send_byte(8'h50, a);
    send_byte(8'hC0, a); send_byte(8'hDE, a);
    bus_stop();
    check("R1 one write after restart", n_wr, 1);
    check("R1 restart address", {24'd0, log_a[0]}, 32'h50);
    check("R8 restart data", {16'd0, log_d[0]}, 32'hC0DE);
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; strap = 2'b00; rel_ok = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_bad_addr();
    t_burst();
    t_mode();
    t_wrap_partial();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule